// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial-bus target that gives a host access to a small bank of 8-bit configuration registers. It watches open-drain clock and data lines, resolves start, repeated start and stop conditions in the system clock domain, and answers a 7-bit bus address whose low bits come from strap inputs. Both bus lines pass through two-flop synchronisers. The target samples data on the clock's rising edge. It changes its data drive only while the clock is low.

Register access is indexed and block-oriented. A write carries a start index, then a byte count, then the data bytes, which go into consecutive registers. A read begins with a write-direction address and the start index. A repeated start and a read-direction address follow. The target then returns a count byte, taken from the last register of the bank, and after that streams register contents from the index. The whole bank is also available on a flat parallel readback port.

Top module: `smb_blk_slave`

## Requirements
- R1: After reset the target does not drive the data line. Register i (for i below NREG-1) holds 0xA0+i, and the count register (index NREG-1, 8 by default) holds NREG.
- R2: The target answers address {BASE_ADDR[6:2], addr_sel}, and the eighth bit of the address byte is the direction (0 = write, 1 = read). An address byte with any other value gets no acknowledge. After it, every byte up to the next start is ignored: it is not acknowledged and writes nothing.
- R3: In a write (address, index N, count X, data bytes), the target acknowledges each byte, and data byte k lands in the register at index N+k.
- R4: A write data byte sent after X bytes have been accepted is not acknowledged and is not stored. The target then ignores the bus until the next start.
- R5: The register index advances by one after each data byte, whether written or read. From NREG-1 or any higher value it advances to 0.
- R6: In a read, the first byte sent after the read address is the current count register value. Register bytes follow from index N, each after a host acknowledge.
- R7: A host not-acknowledge ends the read. The target releases the data line and sends nothing more until the next start.
- R8: A write to index NREG-1 changes the count byte that later reads return first.
- R9: A stop or start at any point ends the current transfer. Data bytes that were already acknowledged stay stored, and a partly received byte is discarded.
- R10: While the synchronised clock stays high, the target's data drive does not change.
- R11: A write to an index of NREG or above is acknowledged but stores nothing. A read from such an index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | STRAP_W | Strap bits forming the low bits of the bus address |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NREG*8 | All registers, register i at bits [8i+7:8i] |

## Verification
The hardest situations to reach are the ones where the target has to stop partway through a transaction. These are a data byte past the declared count, a stop or repeated start in the middle of a byte, and an index walk that crosses the count register and wraps back to zero. The bench drives bit-level host tasks that can cut a byte short, send extra bytes or reissue a start at any bit. It keeps its own copy of the register bank, updated by the index and count rules. Sweeps over every strap value and every start index compare each acknowledge, each returned byte and the parallel readback against that copy.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } st_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_INDEX,
        RL_COUNT,
        RL_WDATA
    } role_e;

    typedef struct packed {
        logic [7:0] sh;
        logic [3:0] cnt;
    } shift_t;

    function automatic logic [7:0] reg_default(int i, int n);
        return (i == n - 1) ? 8'(n) : 8'(8'hA0 + i);
    endfunction

    function automatic logic [7:0] next_index(logic [7:0] idx, int n);
        return (int'(idx) >= n - 1) ? 8'h00 : idx + 8'h01;
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[g] <= 1'b1;
                q[g]    <= 1'b1;
            end else begin
                meta[g] <= d[g];
                q[g]    <= meta[g];
            end
        end
    end
endmodule

// File: rtl/smb_cond.sv
module smb_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/smb_regs.sv
module smb_regs #(
    parameter int NREG = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        waddr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        raddr,
    output logic [7:0]        rdata,
    output logic [7:0]        cnt,
    output logic [NREG*8-1:0] flat
);
    logic [7:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= smb_pkg::reg_default(g, NREG);
            end else if (we && waddr == 8'(g)) begin
                mem[g] <= wdata;
            end
        end
        assign flat[g*8 +: 8] = mem[g];
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == 8'(i)) rdata = mem[i];
        end
    end

    assign cnt = mem[NREG-1];
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave #(
    parameter int         NREG      = 9,
    parameter logic [6:0] BASE_ADDR = 7'h6C,
    parameter int         STRAP_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_sel,
    output logic               sda_oe,
    output logic [NREG*8-1:0]  regs_o
);
    import smb_pkg::*;

    localparam int HI_W = 7 - STRAP_W;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] my_addr;

    st_e        state;
    role_e      role;
    shift_t     rx, tx;
    logic [7:0] idx;
    logic [7:0] wrem;
    logic       rw;
    logic       ack_ok;

    logic       wr_en;
    logic [7:0] rd_byte;
    logic [7:0] cnt_val;
    logic [7:0] idx_nxt;

    smb_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   ({scl_s, sda_s})
    );

    smb_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_regs #(.NREG(NREG)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (idx),
        .wdata (rx.sh),
        .raddr (idx),
        .rdata (rd_byte),
        .cnt   (cnt_val),
        .flat  (regs_o)
    );

    assign my_addr = {BASE_ADDR[6 -: HI_W], addr_sel};
    assign idx_nxt = next_index(idx, NREG);

    always_comb begin
        wr_en = (state == ST_RX) && scl_fall && (rx.cnt == 4'd8)
                && (role == RL_WDATA) && (wrem != 8'd0)
                && !start_det && !stop_det;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            role   <= RL_ADDR;
            rx     <= '0;
            tx     <= '0;
            idx    <= 8'h00;
            wrem   <= 8'h00;
            rw     <= 1'b0;
            ack_ok <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_RX;
            role   <= RL_ADDR;
            rx.cnt <= 4'd0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (scl_rise && rx.cnt < 4'd8) begin
                        rx.sh  <= {rx.sh[6:0], sda_s};
                        rx.cnt <= rx.cnt + 4'd1;
                    end else if (scl_fall && rx.cnt == 4'd8) begin
                        unique case (role)
                            RL_ADDR: begin
                                if (rx.sh[7:1] == my_addr) begin
                                    rw     <= rx.sh[0];
                                    role   <= rx.sh[0] ? RL_ADDR : RL_INDEX;
                                    state  <= ST_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                            RL_INDEX: begin
                                idx    <= rx.sh;
                                role   <= RL_COUNT;
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                            end
                            RL_COUNT: begin
                                wrem   <= rx.sh;
                                role   <= RL_WDATA;
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                            end
                            RL_WDATA: begin
                                if (wrem != 8'd0) begin
                                    idx    <= idx_nxt;
                                    wrem   <= wrem - 8'd1;
                                    state  <= ST_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        rx.cnt <= 4'd0;
                        tx.cnt <= 4'd0;
                        if (rw && role == RL_ADDR) begin
                            tx.sh  <= cnt_val;
                            sda_oe <= ~cnt_val[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (tx.cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            tx.cnt <= 4'd0;
                            state  <= ST_MACK;
                        end else begin
                            tx.sh  <= {tx.sh[6:0], 1'b0};
                            sda_oe <= ~tx.sh[6];
                            tx.cnt <= tx.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        ack_ok <= ~sda_s;
                    end else if (scl_fall) begin
                        if (ack_ok) begin
                            tx.sh  <= rd_byte;
                            tx.cnt <= 4'd0;
                            sda_oe <= ~rd_byte[7];
                            idx    <= idx_nxt;
                            state  <= ST_TX;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_blk_slave_chk.sv
module smb_blk_slave_chk (
    input logic          clk,
    input logic          rst,
    input logic          scl_s,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_oe,
    input smb_pkg::st_e  state,
    input smb_pkg::role_e role
);
    import smb_pkg::*;

    // R1: released and idle on the first cycle out of reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && state == ST_IDLE));

    // R2, R4, R7: silent while ignoring the bus
    a_r2_quiet_when_ignoring: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R3: drives only while acknowledging or transmitting
    a_r3_drive_only_ack_tx: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == ST_ACK || state == ST_TX));

    // R9: stop returns to idle
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE));

    // R9: start restarts address reception
    a_r9_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_RX && role == RL_ADDR));

    // R10: data drive held while clock high
    a_r10_sda_hold: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s) && !$past(rst)) |-> $stable(sda_oe));
endmodule

bind smb_blk_slave smb_blk_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .state     (state),
    .role      (role)
);

// File: tb/smb_blk_slave_tb.sv
module smb_blk_slave_tb;
    localparam int         NREG      = 9;
    localparam logic [6:0] BASE_ADDR = 7'h6C;
    localparam int         Q         = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic [1:0] sel = 2'd1;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic [7:0] exp_reg [NREG];

    always #2 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    smb_blk_slave #(.NREG(NREG), .BASE_ADDR(BASE_ADDR), .STRAP_W(2)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .addr_sel (sel),
        .sda_oe   (sda_oe),
        .regs_o   (regs_o)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [6:0] addr_of(logic [1:0] s);
        return {BASE_ADDR[6:2], s};
    endfunction

    function automatic logic [7:0] nxt(logic [7:0] i);
        return (int'(i) >= NREG - 1) ? 8'h00 : i + 8'h01;
    endfunction

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b, output logic s);
        logic s0;
        sda_h = b; tick(Q);
        scl_h = 1'b1; tick(3);
        s0 = sda_line;
        tick(Q - 3);
        s = sda_line;
        if (s != s0) r10_viol++;
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(v[i], s);
        send_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            v[i] = s;
        end
        send_bit(host_ack ? 1'b0 : 1'b1, s);
    endtask

    task automatic chk_regs(string req);
        for (int i = 0; i < NREG; i++)
            chk(req, $sformatf("reg[%0d]", i), int'(regs_o[i*8 +: 8]), int'(exp_reg[i]));
    endtask

    // write transaction with model update; nsend data bytes of value dbase+k
    task automatic wr_txn(string req, input logic [1:0] asel, input logic [7:0] n,
                          input logic [7:0] x, input int nsend, input logic [7:0] dbase);
        bit a;
        int acks = 0;
        int expect_acks;
        bit match;
        logic [7:0] mi;
        int ngood;
        match = (asel == sel);
        bus_start();
        send_byte({addr_of(asel), 1'b0}, a); acks += int'(a);
        send_byte(n, a); acks += int'(a);
        send_byte(x, a); acks += int'(a);
        for (int k = 0; k < nsend; k++) begin
            send_byte(dbase + 8'(k), a);
            acks += int'(a);
        end
        bus_stop();
        ngood = (nsend < int'(x)) ? nsend : int'(x);
        expect_acks = match ? 3 + ngood : 0;
        chk(req, "acknowledged bytes", acks, expect_acks);
        if (match) begin
            mi = n;
            for (int k = 0; k < ngood; k++) begin
                if (int'(mi) < NREG) exp_reg[mi] = dbase + 8'(k);
                mi = nxt(mi);
            end
        end
    endtask

    task automatic rd_txn(string req, input logic [7:0] n, input int nread);
        bit a;
        int acks = 0;
        logic [7:0] v;
        logic [7:0] mi;
        logic [7:0] ev;
        bus_start();
        send_byte({addr_of(sel), 1'b0}, a); acks += int'(a);
        send_byte(n, a); acks += int'(a);
        bus_start();
        send_byte({addr_of(sel), 1'b1}, a); acks += int'(a);
        chk(req, "read setup acks", acks, 3);
        recv_byte(nread > 0, v);
        chk("R6/R8", "count byte", int'(v), int'(exp_reg[NREG-1]));
        mi = n;
        for (int k = 0; k < nread; k++) begin
            recv_byte(k < nread - 1, v);
            ev = (int'(mi) < NREG) ? exp_reg[mi] : 8'h00;
            chk(req, $sformatf("read byte idx %0d", mi), int'(v), int'(ev));
            mi = nxt(mi);
        end
        chk("R7", "released after host nack", int'(sda_oe), 0);
        bus_stop();
        chk("R7", "released after stop", int'(sda_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit a;
        logic s;
        for (int i = 0; i < NREG; i++)
            exp_reg[i] = (i == NREG - 1) ? 8'(NREG) : 8'(8'hA0 + i);
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1: reset state
        chk("R1", "sda_oe after reset", int'(sda_oe), 0);
        chk_regs("R1");

        // R2, R3: every strap value, write two bytes
        for (int sv = 0; sv < 4; sv++) begin
            sel = 2'(sv);
            tick(Q);
            wr_txn("R2/R3", 2'(sv), 8'(sv * 2), 8'd2, 2, 8'(8'h10 * (sv + 1)));
            chk_regs("R3");
        end

        // R2: wrong address gets nothing, later bytes ignored
        sel = 2'd1;
        tick(Q);
        wr_txn("R2", 2'd2, 8'd0, 8'd3, 3, 8'hEE);
        chk_regs("R2");

        // R4: bytes past the count are refused
        wr_txn("R4", 2'd1, 8'd3, 8'd1, 3, 8'h77);
        chk_regs("R4");

        // R5: write wraps through count register to index 0
        wr_txn("R5", 2'd1, 8'd7, 8'd3, 3, 8'h42);
        chk_regs("R5");
        // restore count register to a known value
        wr_txn("R8", 2'd1, 8'd8, 8'd1, 1, 8'd4);
        chk_regs("R8");

        // R6, R5: read sweep over every start index, crossing the wrap
        for (int n = 0; n < NREG; n++) rd_txn("R6/R5", 8'(n), 3);

        // R8: count register drives first read byte
        wr_txn("R8", 2'd1, 8'd8, 8'd1, 1, 8'h05);
        rd_txn("R8", 8'd0, 1);

        // R9: stop in the middle of a byte
        bus_start();
        send_byte({addr_of(sel), 1'b0}, a);
        send_byte(8'd2, a);
        send_byte(8'd3, a);
        send_byte(8'h5A, a);
        chk("R9", "first data byte acked", int'(a), 1);
        exp_reg[2] = 8'h5A;
        for (int i = 0; i < 4; i++) send_bit(1'b1, s);
        bus_stop();
        chk_regs("R9");

        // R9: repeated start in the middle of a byte
        bus_start();
        send_byte({addr_of(sel), 1'b0}, a);
        send_byte(8'd4, a);
        send_byte(8'd2, a);
        for (int i = 0; i < 3; i++) send_bit(1'b0, s);
        bus_start();
        send_byte({addr_of(sel), 1'b0}, a);
        send_byte(8'd5, a);
        send_byte(8'd1, a);
        send_byte(8'h33, a);
        chk("R9", "byte after restart acked", int'(a), 1);
        bus_stop();
        exp_reg[5] = 8'h33;
        chk_regs("R9");

        // R11: out-of-range index
        wr_txn("R11", 2'd1, 8'd12, 8'd1, 1, 8'h99);
        chk_regs("R11");
        rd_txn("R11", 8'd12, 2);

        // R10: no drive change observed while clock high
        chk("R10", "drive changes during clock high", r10_viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule